// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block is a down-counting interrupt timer. A bus-side decoder, which lies outside the block, turns register writes into a set of strobes. There is one strobe for the control register and one strobe per byte lane of the count value. Every strobe shares a single data byte. While counting is enabled, the counter steps down once on each cycle in which the processor-clock enable is high. When it reaches zero it stops there and raises an interrupt line. That line stays high until software writes the control register again.

A mode input selects how the count value is loaded. In direct mode, a byte write lands straight in the live counter. In latched mode, a byte write lands in a holding latch. The whole latch is then copied into the counter when the control register is written, and that same write also acknowledges the interrupt.

There is no data stream through the block. Every strobe is accepted in the cycle in which it is high. Nothing stalls and nothing pushes back, so the block needs no valid/ready pair. All pins are plain control and status.

Top module: `cyc_irq_timer`

## Requirements
- R1: Reset clears the counter, the latch, the enable and the interrupt. The `irq` output is 0 after reset. A first enable right after reset finds a zero value in both modes.
- R2: A control write sets the enable from `wdata` bit 0 (1 = count, 0 = hold). While disabled, the counter keeps its value and no interrupt arises from counting.
- R3: While enabled, the counter decreases by one at each clock edge where `tick_en` is 1 and no control write or direct byte write occurs. It stays at zero and never wraps.
- R4: The interrupt rises at the edge where an enabled counter becomes zero. It then stays high until a control write.
- R5: Every control write clears a pending interrupt.
- R6: A control write with bit 0 = 1 raises the interrupt at that same edge if the value the counter holds after the write is zero.
- R7: In direct mode, `byte_we[0]` writes bits 7:0 of the counter and `byte_we[1]` writes bits 15:8, which is little-endian. A byte write overrides the decrement in that cycle, and a byte that is not written keeps its value.
- R8: In latched mode, byte writes change only the latch. The counter keeps counting as if the write had not happened.
- R9: In latched mode, a control write copies the latch into the counter. The zero check for R6 uses the newly loaded value.
- R10: `latch_mode` = 0 selects direct mode and 1 selects latched mode. In direct mode, a control write leaves the counter untouched and ignores the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle processor-clock enable for counting |
| latch_mode | input | 1 | 0 = direct load, 1 = latched load |
| ctrl_we | input | 1 | Control register write strobe |
| byte_we | input | CNT_W/BYTE_W | Count byte-lane write strobes, bit 0 = least significant lane |
| wdata | input | BYTE_W | Write data byte |
| irq | output | 1 | Interrupt, held until the next control write |

## Verification
The bench builds the block with its default parameters: a 16-bit counter split into two 8-bit lanes. This lets it check that the high lane carries weight 256 and that the lanes are little-endian, using a load of 258 that expires within a few hundred cycles. It never reads the counter. Instead, it infers every load, pause and override from the exact cycle at which `irq` rises, so a wrong value shifts a rise that is predicted to the cycle. Small loads, paused ticks and mode switches reach the zero-hold, immediate-interrupt and latch-reload corner cases within a short run.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

  typedef enum logic {
    LOAD_DIRECT  = 1'b0,
    LOAD_LATCHED = 1'b1
  } load_mode_e;

  // Bit of the control byte that turns counting on.
  localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/irqtmr_latch.sv
module irqtmr_latch
  import irqtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  load_mode_e        mode,
  input  logic [NB-1:0]     byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  latch_q
);

  // One holding register per byte lane, written only in latched mode.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (mode == LOAD_LATCHED && byte_we[g]) begin
        lane_q <= wdata;
      end
    end

    assign latch_q[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/irqtmr_counter.sv
module irqtmr_counter
  import irqtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  load_mode_e        mode,
  input  logic              tick_en,
  input  logic              en_q,
  input  logic              ctrl_we,
  input  logic [NB-1:0]     byte_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  latch_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              cnt_zero_d
);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] merged;
  logic             direct_wr;
  logic             reload;
  logic             dec;

  always_comb begin
    merged = cnt_q;
    for (int i = 0; i < NB; i++) begin
      if (byte_we[i]) merged[i*BYTE_W +: BYTE_W] = wdata;
    end
  end

  assign reload    = ctrl_we && (mode == LOAD_LATCHED);
  assign direct_wr = (mode == LOAD_DIRECT) && (|byte_we);
  assign dec       = en_q && tick_en && !ctrl_we && (cnt_q != '0);

  // Priority: latch reload, then direct byte write, then decrement.
  always_comb begin
    if (reload)         cnt_d = latch_q;
    else if (direct_wr) cnt_d = merged;
    else if (dec)       cnt_d = cnt_q - 1'b1;
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_zero_d = (cnt_d == '0);

endmodule

// File: rtl/irqtmr_ctrl.sv
module irqtmr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic en_bit,
  input  logic cnt_zero_d,
  output logic en_q,
  output logic irq_q
);

  logic en_d;
  logic irq_d;

  assign en_d  = ctrl_we ? en_bit : en_q;
  // A control write acknowledges the interrupt. The zero test then
  // looks at the value the counter will hold after this edge.
  assign irq_d = (ctrl_we ? 1'b0 : irq_q) | (en_d && cnt_zero_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import irqtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              latch_mode,
  input  logic              ctrl_we,
  input  logic [NB-1:0]     byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic              irq
);

  load_mode_e       mode;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero_d;
  logic             en_q;

  assign mode = load_mode_e'(latch_mode);

  irqtmr_latch #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .byte_we (byte_we),
    .wdata   (wdata),
    .latch_q (latch_q)
  );

  irqtmr_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .tick_en    (tick_en),
    .en_q       (en_q),
    .ctrl_we    (ctrl_we),
    .byte_we    (byte_we),
    .wdata      (wdata),
    .latch_q    (latch_q),
    .cnt_q      (cnt_q),
    .cnt_zero_d (cnt_zero_d)
  );

  irqtmr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .en_bit     (wdata[CTRL_EN_BIT]),
    .cnt_zero_d (cnt_zero_d),
    .en_q       (en_q),
    .irq_q      (irq)
  );

endmodule

// File: rtl/irqtmr_chk.sv
module irqtmr_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              latch_mode,
  input logic              ctrl_we,
  input logic [NB-1:0]     byte_we,
  input logic [BYTE_W-1:0] wdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  latch_q,
  input logic              en_q,
  input logic              irq
);

  logic dwr;
  assign dwr = !latch_mode && (|byte_we);

  assert_enable_follows_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> en_q == $past(wdata[0]));

  assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_we && !dwr) |=> $stable(cnt_q));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_en && cnt_q != '0 && !ctrl_we && !dwr) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ctrl_we && !dwr) |=> cnt_q == '0);

  assert_rise_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_en && cnt_q == 1 && !ctrl_we && !dwr) |=> irq);

  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_we) |=> irq);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wdata[0]) |=> !irq);

  assert_enable_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[0] && latch_mode && latch_q == '0) |=> irq);

  assert_low_lane_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && byte_we[0] && !ctrl_we) |=> cnt_q[BYTE_W-1:0] == $past(wdata));

  assert_latch_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && (|byte_we) && !ctrl_we && !(en_q && tick_en)) |=> $stable(cnt_q));

  assert_reload_from_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && latch_mode) |=> cnt_q == $past(latch_q));

  assert_direct_ctrl_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !latch_mode && !(|byte_we)) |=> $stable(cnt_q));

endmodule

bind cyc_irq_timer irqtmr_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .latch_mode (latch_mode),
  .ctrl_we    (ctrl_we),
  .byte_we    (byte_we),
  .wdata      (wdata),
  .cnt_q      (cnt_q),
  .latch_q    (latch_q),
  .en_q       (en_q),
  .irq        (irq)
);

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       latch_mode = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [1:0] byte_we = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic       irq;

  cyc_irq_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .latch_mode (latch_mode),
    .ctrl_we    (ctrl_we),
    .byte_we    (byte_we),
    .wdata      (wdata),
    .irq        (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  exp;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // Scoreboard entry: irq must equal v just after posedge number due.
  task automatic expect_at(int due, logic v, string req);
    exp_t e;
    e.due = due;
    e.exp = v;
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: samples a quarter period after each rising edge.
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (e.due != cyc || irq !== e.exp) begin
        n_fail++;
        $display("FAIL %s: cycle %0d irq=%b expected %b (due %0d)",
                 e.req, cyc, irq, e.exp, e.due);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ctrl(logic en);
    ctrl_we = 1'b1;
    wdata   = {7'b0, en};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic do_byte(int lane, logic [7:0] v);
    byte_we = 2'(1 << lane);
    wdata   = v;
    @(negedge clk);
    byte_we = 2'b00;
  endtask

  task automatic direct_load(logic [15:0] v);
    latch_mode = 1'b0;
    do_ctrl(1'b0);
    do_byte(0, v[7:0]);
    do_byte(1, v[15:8]);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    int e;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: quiet after reset
    expect_at(cyc + 1, 1'b0, "R1 reset irq");
    expect_at(cyc + 3, 1'b0, "R1 reset irq");
    idle(4);

    // R6 + R1: enable with cleared counter fires at once
    latch_mode = 1'b0;
    e = cyc + 1;
    expect_at(e, 1'b1, "R6 enable at zero");
    do_ctrl(1'b1);
    idle(2);

    // R5: control write acknowledges
    e = cyc + 1;
    expect_at(e, 1'b0, "R5 ack");
    do_ctrl(1'b0);
    idle(2);

    // R3/R4: count down from 5, hold, no wrap
    direct_load(16'd5);
    e = cyc + 1;
    expect_at(e,      1'b0, "R3 counting");
    expect_at(e + 4,  1'b0, "R3 counting");
    expect_at(e + 5,  1'b1, "R4 rise at zero");
    expect_at(e + 12, 1'b1, "R4 held");
    do_ctrl(1'b1);
    idle(14);
    e = cyc + 1;
    expect_at(e, 1'b1, "R3 stays at zero");
    do_ctrl(1'b1);
    idle(1);
    e = cyc + 1;
    expect_at(e, 1'b0, "R5 ack");
    do_ctrl(1'b0);
    idle(1);

    // R7: little-endian lanes, 0x0102 = 258
    direct_load(16'h0102);
    e = cyc + 1;
    expect_at(e + 257, 1'b0, "R7 high lane weight");
    expect_at(e + 258, 1'b1, "R7 high lane weight");
    do_ctrl(1'b1);
    idle(260);

    // R2: pause keeps the count
    direct_load(16'd10);
    do_ctrl(1'b1);
    idle(3);
    do_ctrl(1'b0);
    expect_at(cyc + 10, 1'b0, "R2 paused");
    idle(20);
    e = cyc + 1;
    expect_at(e + 6, 1'b0, "R2 resume");
    expect_at(e + 7, 1'b1, "R2 resume");
    do_ctrl(1'b1);
    idle(9);

    // R3: only cycles with tick_en count
    direct_load(16'd4);
    e = cyc + 1;
    do_ctrl(1'b1);
    tick_en = 1'b0;
    expect_at(e + 13, 1'b0, "R3 tick gating");
    expect_at(e + 14, 1'b1, "R3 tick gating");
    idle(10);
    tick_en = 1'b1;
    idle(6);

    // R7: byte write overrides decrement
    direct_load(16'd50);
    e = cyc + 1;
    expect_at(e + 7, 1'b0, "R7 write priority");
    expect_at(e + 8, 1'b1, "R7 write priority");
    do_ctrl(1'b1);
    idle(4);
    do_byte(0, 8'd3);
    idle(5);

    // R8: latched-mode byte writes leave the counter alone
    latch_mode = 1'b1;
    do_ctrl(1'b0);
    do_byte(0, 8'd20);
    do_byte(1, 8'd0);
    e = cyc + 1;
    expect_at(e + 6,  1'b0, "R8 latch only");
    expect_at(e + 19, 1'b0, "R8 latch only");
    expect_at(e + 20, 1'b1, "R8 latch only");
    do_ctrl(1'b1);
    idle(2);
    do_byte(0, 8'd2);
    idle(19);

    // R9: control write reloads from latch (now 2)
    e = cyc + 1;
    expect_at(e,     1'b0, "R9 reload ack");
    expect_at(e + 1, 1'b0, "R9 reload");
    expect_at(e + 2, 1'b1, "R9 reload");
    do_ctrl(1'b1);
    idle(4);

    // R9: zero test uses the new value (latch 0, counter 9)
    direct_load(16'd9);
    latch_mode = 1'b1;
    do_byte(0, 8'd0);
    e = cyc + 1;
    expect_at(e, 1'b1, "R9 zero check on loaded value");
    do_ctrl(1'b1);
    idle(3);

    // R9: counter 0, latch 7 -> no immediate irq
    do_byte(0, 8'd7);
    e = cyc + 1;
    expect_at(e,     1'b0, "R9 nonzero load");
    expect_at(e + 6, 1'b0, "R9 nonzero load");
    expect_at(e + 7, 1'b1, "R9 nonzero load");
    do_ctrl(1'b1);
    idle(9);

    // R10: direct mode ignores the latch on control write
    direct_load(16'd3);
    e = cyc + 1;
    expect_at(e + 2, 1'b0, "R10 direct ignores latch");
    expect_at(e + 3, 1'b1, "R10 direct ignores latch");
    do_ctrl(1'b1);
    idle(5);

    // R1: reset also clears the latch
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    expect_at(cyc + 1, 1'b0, "R1 reset clears irq");
    idle(2);
    latch_mode = 1'b1;
    e = cyc + 1;
    expect_at(e, 1'b1, "R1 latch cleared");
    do_ctrl(1'b1);
    idle(3);

    if (q.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL scoreboard: %0d unchecked items, expected 0", q.size());
    end
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: cycle %0d reached, expected completion", cyc);
      finish_run();
    end
  end

endmodule